// File: doc/BRIEF.md
# Per-User Repeated-Exceedance Injection Blocker

This block works at the end of each machine cycle, before the next cycle starts. It is handed the peak value that every loss channel reached in each of its integration windows during the cycle. It is also handed the index of the user (beam destination) that owned that cycle. It compares every channel/window peak with a slow threshold held for that exact user, channel and window. This threshold set is separate from any fast per-sample protection. For each user/channel pair a counter records on how many cycles that channel went over. When a counter reaches the repeat limit set for its channel, the block withdraws that one user's injection permit and holds it withdrawn.

The peaks arrive as one transfer on a valid/ready stream. After a transfer is taken, the block walks through the channel/window pairs one per clock. It then applies the cycle's result to the counters and the permit latches, and pulses `done`. An operator acknowledge names one user and restores that user's permit and counters. Thresholds and per-channel limits are loaded through plain write strobes. A configuration bit chooses whether a clean cycle clears a channel's count.

Top module: `user_rep_blocker`

## Requirements
- R1: After reset every bit of `permit` is 1, `cyc_ready` is 1, `done` is 0, `over_mask` is 0, every repeat count is 0 and every channel limit code is 15.
- R2: Channel c of a cycle exceeds when, for at least one window w, the peak in `cyc_max[(c*NUM_WIN+w)*DATA_W +: DATA_W]` is strictly greater than the threshold written for (`cyc_user`, c, w). An equal value does not exceed. `over_mask[c]` shows this after `done` and holds until the next transfer is taken. Thresholds of different users are independent.
- R3: A transfer is taken on a clock edge with `cyc_valid` and `cyc_ready` both high. `cyc_ready` is then low until `done` rises on the 33rd edge after the taking edge (default sizes), and `cyc_ready` returns on that same edge. `done` lasts one cycle. A `cyc_valid` held high while busy is not taken a second time. The sender may hold or change its data freely while `cyc_ready` is low.
- R4: A channel's count rises by exactly one per cycle in which it exceeds, however many of its windows are over.
- R5: The limit code k (4 bits) written for a channel sets a repeat limit n = k+1, from 1 to 16. A user's `permit` bit drops on the `done` edge of the cycle that brings any of its channel counts to n. With k = 0 the first exceedance blocks. Counts saturate at n.
- R6: A cycle changes only the counts and the permit of the user that owned it. At most one permit bit drops per cycle.
- R7: A dropped permit stays 0 through later cycles of that user, clean or not, until acknowledged.
- R8: A one-cycle `ack_valid` pulse sets `permit[ack_user]` back to 1 and clears that user's counts, and touches no other user. If it lands on the same edge as that user's update, the acknowledge wins. A permit bit rises only through an acknowledge.
- R9: With `cfg_clr_clean` = 1, a cycle in which a channel does not exceed clears that channel's count for the owning user. With `cfg_clr_clean` = 0 the count holds.
- R10: Counts are kept per channel. Exceedances spread over different channels never add up toward one channel's limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thr_we | input | 1 | Threshold write strobe |
| cfg_thr_user | input | $clog2(NUM_USERS) | User index of the threshold write |
| cfg_thr_ch | input | $clog2(NUM_CH) | Channel index of the threshold write |
| cfg_thr_win | input | $clog2(NUM_WIN) | Window index of the threshold write |
| cfg_thr_data | input | DATA_W | Threshold value |
| cfg_lim_we | input | 1 | Limit code write strobe |
| cfg_lim_ch | input | $clog2(NUM_CH) | Channel whose limit code is written |
| cfg_lim_code | input | LIM_W | Limit code k, repeat limit k+1 |
| cfg_clr_clean | input | 1 | Clean cycle clears the channel count when 1 |
| cyc_valid | input | 1 | End-of-cycle peaks are offered |
| cyc_ready | output | 1 | Block is idle and takes a transfer |
| cyc_user | input | $clog2(NUM_USERS) | User that owned the cycle |
| cyc_max | input | NUM_CH*NUM_WIN*DATA_W | Window peaks, pair (c,w) at slot c*NUM_WIN+w |
| ack_valid | input | 1 | Operator acknowledge pulse |
| ack_user | input | $clog2(NUM_USERS) | User to restore |
| permit | output | NUM_USERS | Per-user injection permit, 1 = allowed |
| over_mask | output | NUM_CH | Channels that exceeded in the last evaluated cycle |
| done | output | 1 | One-cycle pulse when a cycle's result has been applied |

## Verification
On every cycle the assertions check several handshake and permit rules. Taking a transfer drops `cyc_ready`. `done` is a single pulse that coincides with the return of `cyc_ready`. A permit bit falls only with `done`, and for at most one user at a time. A permit bit rises only for the user named by the acknowledge of the previous edge. Whether the right user falls after the right number of exceedances cannot be seen from one cycle. The same holds for the strict comparison at equality, the effect of the clean-clear bit, the per-channel separation of counts and the exact scan latency. Only the bench's scenarios can show these, with a reference model of thresholds, limits and counts.

// File: rtl/urb_pkg.sv
package urb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_UPD  = 2'd2
  } urb_state_e;

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/urb_thr_store.sv
module urb_thr_store #(
  parameter int NUM_USERS = 32,
  parameter int NUM_CH    = 8,
  parameter int NUM_WIN   = 4,
  parameter int DATA_W    = 16
) (
  input  logic                                     clk,
  input  logic                                     wr_en,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] wr_user,
  input  logic [urb_pkg::safe_clog2(NUM_CH)-1:0]    wr_ch,
  input  logic [urb_pkg::safe_clog2(NUM_WIN)-1:0]   wr_win,
  input  logic [DATA_W-1:0]                        wr_data,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] rd_user,
  input  logic [urb_pkg::safe_clog2(NUM_CH)-1:0]    rd_ch,
  input  logic [urb_pkg::safe_clog2(NUM_WIN)-1:0]   rd_win,
  output logic [DATA_W-1:0]                        rd_data
);
  localparam int DEPTH = NUM_USERS * NUM_CH * NUM_WIN;
  localparam int AW    = urb_pkg::safe_clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_addr, rd_addr;

  // flat slot: user-major, then channel, then window
  assign wr_addr = AW'((int'(wr_user) * NUM_CH + int'(wr_ch)) * NUM_WIN + int'(wr_win));
  assign rd_addr = AW'((int'(rd_user) * NUM_CH + int'(rd_ch)) * NUM_WIN + int'(rd_win));

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/urb_scan_ctrl.sv
module urb_scan_ctrl #(
  parameter int NUM_USERS = 32,
  parameter int NUM_CH    = 8,
  parameter int NUM_WIN   = 4,
  parameter int DATA_W    = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cyc_valid,
  output logic                                     cyc_ready,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] cyc_user,
  input  logic [NUM_CH*NUM_WIN*DATA_W-1:0]         cyc_max,
  output logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] rd_user,
  output logic [urb_pkg::safe_clog2(NUM_CH)-1:0]    rd_ch,
  output logic [urb_pkg::safe_clog2(NUM_WIN)-1:0]   rd_win,
  input  logic [DATA_W-1:0]                        thr_data,
  output logic                                     upd,
  output logic [NUM_CH-1:0]                        over_mask,
  output logic                                     done
);
  import urb_pkg::*;

  localparam int NPAIR = NUM_CH * NUM_WIN;
  localparam int PW    = safe_clog2(NPAIR);
  localparam int CW    = safe_clog2(NUM_CH);
  localparam int WW    = safe_clog2(NUM_WIN);
  localparam int UW    = safe_clog2(NUM_USERS);
  localparam logic [PW-1:0] LAST = PW'(NPAIR - 1);

  urb_state_e                    state_q;
  logic [PW-1:0]                 idx_q;
  logic [UW-1:0]                 user_q;
  logic [NPAIR*DATA_W-1:0]       max_q;
  logic [NUM_CH-1:0]             mask_q;
  logic                          done_q;
  logic [DATA_W-1:0]             cur_max;
  logic                          exceed;

  assign rd_user = user_q;
  assign rd_ch   = CW'(int'(idx_q) / NUM_WIN);
  assign rd_win  = WW'(int'(idx_q) % NUM_WIN);
  assign cur_max = max_q[int'(idx_q)*DATA_W +: DATA_W];
  assign exceed  = cur_max > thr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      user_q  <= '0;
      max_q   <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cyc_valid) begin
          user_q  <= cyc_user;
          max_q   <= cyc_max;
          mask_q  <= '0;
          idx_q   <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (exceed) mask_q[rd_ch] <= 1'b1;
          if (idx_q == LAST) state_q <= ST_UPD;
          else               idx_q   <= idx_q + PW'(1);
        end
        ST_UPD: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cyc_ready = (state_q == ST_IDLE);
  assign upd       = (state_q == ST_UPD);
  assign over_mask = mask_q;
  assign done      = done_q;
endmodule

// File: rtl/urb_rep_bank.sv
module urb_rep_bank #(
  parameter int NUM_USERS = 32,
  parameter int NUM_CH    = 8,
  parameter int LIM_W     = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     lim_we,
  input  logic [urb_pkg::safe_clog2(NUM_CH)-1:0]    lim_ch,
  input  logic [LIM_W-1:0]                         lim_code,
  input  logic                                     clr_clean,
  input  logic                                     upd,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] upd_user,
  input  logic [NUM_CH-1:0]                        upd_mask,
  input  logic                                     ack_valid,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] ack_user,
  output logic [NUM_USERS-1:0]                     permit
);
  localparam int UW    = urb_pkg::safe_clog2(NUM_USERS);
  localparam int CNT_W = LIM_W + 1;

  logic [LIM_W-1:0] lim_q [NUM_CH];
  logic [CNT_W-1:0] lim_n [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) lim_q[c] <= '1;
    end else if (lim_we) begin
      lim_q[lim_ch] <= lim_code;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) lim_n[c] = CNT_W'(lim_q[c]) + CNT_W'(1);
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic [CNT_W-1:0] cnt_q [NUM_CH];
    logic             lat_q;
    logic             hit_ack, hit_upd;

    assign hit_ack = ack_valid && (ack_user == UW'(u));
    assign hit_upd = upd && (upd_user == UW'(u));

    always_ff @(posedge clk) begin
      if (!rst_n || hit_ack) begin
        for (int c = 0; c < NUM_CH; c++) cnt_q[c] <= '0;
        lat_q <= 1'b0;
      end else if (hit_upd) begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (upd_mask[c]) begin
            if (cnt_q[c] < lim_n[c]) cnt_q[c] <= cnt_q[c] + CNT_W'(1);
            if (cnt_q[c] + CNT_W'(1) >= lim_n[c]) lat_q <= 1'b1;
          end else if (clr_clean) begin
            cnt_q[c] <= '0;
          end
        end
      end
    end

    assign permit[u] = ~lat_q;
  end
endmodule

// File: rtl/user_rep_blocker.sv
module user_rep_blocker #(
  parameter int NUM_USERS = 32,
  parameter int NUM_CH    = 8,
  parameter int NUM_WIN   = 4,
  parameter int DATA_W    = 16,
  parameter int LIM_W     = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_thr_we,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] cfg_thr_user,
  input  logic [urb_pkg::safe_clog2(NUM_CH)-1:0]    cfg_thr_ch,
  input  logic [urb_pkg::safe_clog2(NUM_WIN)-1:0]   cfg_thr_win,
  input  logic [DATA_W-1:0]                        cfg_thr_data,
  input  logic                                     cfg_lim_we,
  input  logic [urb_pkg::safe_clog2(NUM_CH)-1:0]    cfg_lim_ch,
  input  logic [LIM_W-1:0]                         cfg_lim_code,
  input  logic                                     cfg_clr_clean,
  input  logic                                     cyc_valid,
  output logic                                     cyc_ready,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] cyc_user,
  input  logic [NUM_CH*NUM_WIN*DATA_W-1:0]         cyc_max,
  input  logic                                     ack_valid,
  input  logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] ack_user,
  output logic [NUM_USERS-1:0]                     permit,
  output logic [NUM_CH-1:0]                        over_mask,
  output logic                                     done
);
  localparam int UW = urb_pkg::safe_clog2(NUM_USERS);
  localparam int CW = urb_pkg::safe_clog2(NUM_CH);
  localparam int WW = urb_pkg::safe_clog2(NUM_WIN);

  logic [UW-1:0]     rd_user;
  logic [CW-1:0]     rd_ch;
  logic [WW-1:0]     rd_win;
  logic [DATA_W-1:0] thr_data;
  logic              upd;

  urb_thr_store #(
    .NUM_USERS(NUM_USERS), .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .DATA_W(DATA_W)
  ) thr_i (
    .clk(clk), .wr_en(cfg_thr_we), .wr_user(cfg_thr_user), .wr_ch(cfg_thr_ch),
    .wr_win(cfg_thr_win), .wr_data(cfg_thr_data),
    .rd_user(rd_user), .rd_ch(rd_ch), .rd_win(rd_win), .rd_data(thr_data)
  );

  urb_scan_ctrl #(
    .NUM_USERS(NUM_USERS), .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .DATA_W(DATA_W)
  ) scan_i (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_user(cyc_user), .cyc_max(cyc_max), .rd_user(rd_user), .rd_ch(rd_ch),
    .rd_win(rd_win), .thr_data(thr_data), .upd(upd), .over_mask(over_mask),
    .done(done)
  );

  urb_rep_bank #(
    .NUM_USERS(NUM_USERS), .NUM_CH(NUM_CH), .LIM_W(LIM_W)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .lim_we(cfg_lim_we), .lim_ch(cfg_lim_ch),
    .lim_code(cfg_lim_code), .clr_clean(cfg_clr_clean), .upd(upd),
    .upd_user(rd_user), .upd_mask(over_mask), .ack_valid(ack_valid),
    .ack_user(ack_user), .permit(permit)
  );
endmodule

// File: rtl/urb_checker.sv
module urb_checker #(
  parameter int NUM_USERS = 32
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     cyc_valid,
  input logic                                     cyc_ready,
  input logic                                     ack_valid,
  input logic [urb_pkg::safe_clog2(NUM_USERS)-1:0] ack_user,
  input logic [NUM_USERS-1:0]                     permit,
  input logic                                     done
);
  logic [NUM_USERS-1:0] permit_q, ack_oh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permit_q <= '1;
      ack_oh_q <= '0;
    end else begin
      permit_q <= permit;
      ack_oh_q <= ack_valid ? (NUM_USERS'(1) << ack_user) : '0;
    end
  end

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_ready |=> !cyc_ready); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc_ready); // R3
  AST_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(permit_q & ~permit)) |-> done); // R5
  AST_ONE_USER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(permit_q & ~permit) <= 1); // R6
  AST_RISE_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (permit & ~permit_q & ~ack_oh_q) == '0); // R8
endmodule

bind user_rep_blocker urb_checker #(.NUM_USERS(NUM_USERS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
  .ack_valid(ack_valid), .ack_user(ack_user), .permit(permit), .done(done)
);

// File: tb/user_rep_blocker_tb_top.sv
module user_rep_blocker_tb_top;
  localparam int NU = 32, NC = 8, NW = 4, DW = 16, LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_thr_we = 0, cfg_lim_we = 0, cfg_clr_clean = 0;
  logic [4:0]    cfg_thr_user = 0;
  logic [2:0]    cfg_thr_ch = 0, cfg_lim_ch = 0;
  logic [1:0]    cfg_thr_win = 0;
  logic [DW-1:0] cfg_thr_data = 0;
  logic [LW-1:0] cfg_lim_code = 0;
  logic          cyc_valid = 0, ack_valid = 0;
  logic [4:0]    cyc_user = 0, ack_user = 0;
  logic [NC*NW*DW-1:0] cyc_max = '0;
  logic          cyc_ready, done;
  logic [NU-1:0] permit;
  logic [NC-1:0] over_mask;

  user_rep_blocker dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  int thr_m [NU][NC][NW];
  int lim_m [NC];
  int cnt_m [NU][NC];
  bit lat_m [NU];
  bit clr_m = 0;
  int mxa   [NC][NW];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_mask(input int u);
    logic [NC-1:0] m = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if (mxa[c][w] > thr_m[u][c][w]) m[c] = 1'b1;
    return m;
  endfunction

  function automatic logic [NU-1:0] exp_perm();
    logic [NU-1:0] p;
    for (int u = 0; u < NU; u++) p[u] = !lat_m[u];
    return p;
  endfunction

  task automatic model_update(input int u, input logic [NC-1:0] m);
    for (int c = 0; c < NC; c++) begin
      if (m[c]) begin
        if (cnt_m[u][c] < lim_m[c] + 1) cnt_m[u][c]++;
        if (cnt_m[u][c] >= lim_m[c] + 1) lat_m[u] = 1;
      end else if (clr_m) cnt_m[u][c] = 0;
    end
  endtask

  task automatic load_max();
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        cyc_max[(c*NW+w)*DW +: DW] = DW'(mxa[c][w]);
  endtask

  task automatic clear_mx();
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) mxa[c][w] = 0;
  endtask

  task automatic wr_thr(input int u, input int c, input int w, input int v);
    @(negedge clk);
    cfg_thr_we = 1; cfg_thr_user = 5'(u); cfg_thr_ch = 3'(c);
    cfg_thr_win = 2'(w); cfg_thr_data = DW'(v);
    thr_m[u][c][w] = v;
    @(negedge clk);
    cfg_thr_we = 0;
  endtask

  task automatic set_lim(input int c, input int code);
    @(negedge clk);
    cfg_lim_we = 1; cfg_lim_ch = 3'(c); cfg_lim_code = LW'(code);
    lim_m[c] = code;
    @(negedge clk);
    cfg_lim_we = 0;
  endtask

  task automatic set_clr(input bit v);
    @(negedge clk);
    cfg_clr_clean = v; clr_m = v;
  endtask

  task automatic do_ack(input int u);
    @(negedge clk);
    ack_valid = 1; ack_user = 5'(u);
    @(negedge clk);
    ack_valid = 0;
    lat_m[u] = 0;
    for (int c = 0; c < NC; c++) cnt_m[u][c] = 0;
    check("R8 ack restores only that user", 64'(permit), 64'(exp_perm()));
  endtask

  // one end-of-cycle transfer; done expected at the 34th falling edge counted
  // from the first falling edge after the taking edge (33 rising edges later)
  task automatic run_cycle(input int u, input string tag);
    logic [NC-1:0] em;
    int k;
    em = exp_mask(u);
    @(negedge clk);
    check("R3 ready when idle", 64'(cyc_ready), 64'(1));
    cyc_user = 5'(u); load_max(); cyc_valid = 1;
    @(negedge clk);
    cyc_valid = 0; k = 1;
    while (!done && k < 100) begin @(negedge clk); k++; end
    check("R3 latency to done", 64'(k), 64'(34));
    model_update(u, em);
    check({tag, " over_mask"}, 64'(over_mask), 64'(em));
    check({tag, " permit"}, 64'(permit), 64'(exp_perm()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int u = 0; u < NU; u++) begin
      lat_m[u] = 0;
      for (int c = 0; c < NC; c++) cnt_m[u][c] = 0;
    end
    for (int c = 0; c < NC; c++) lim_m[c] = 15;
    clear_mx();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 permit after reset", 64'(permit), 64'({NU{1'b1}}));
    check("R1 ready after reset", 64'(cyc_ready), 64'(1));
    check("R1 done after reset", 64'(done), 64'(0));
    check("R1 over_mask after reset", 64'(over_mask), 64'(0));

    for (int u = 0; u < NU; u++)
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < NW; w++) wr_thr(u, c, w, 1000);

    // R1: default limit 16 -> 15 exceedances keep the permit
    clear_mx(); mxa[4][0] = 1500;
    for (int i = 0; i < 15; i++) run_cycle(20, "R1 default limit");
    check("R1 limit 16 not yet reached", 64'(permit[20]), 64'(1));
    run_cycle(20, "R1 default limit");
    check("R1 blocked on 16th", 64'(permit[20]), 64'(0));
    do_ack(20);

    // R2 strict comparison and per-user thresholds
    clear_mx(); mxa[0][2] = 1000;
    run_cycle(3, "R2 equal is clean");
    mxa[0][2] = 1001;
    run_cycle(3, "R2 one above exceeds");
    check("R2 channel0 flagged", 64'(over_mask), 64'(1));
    wr_thr(11, 0, 0, 50);
    clear_mx(); mxa[0][0] = 500;
    run_cycle(11, "R2 low user threshold");
    check("R2 user11 exceeds", 64'(over_mask[0]), 64'(1));
    run_cycle(12, "R2 other user threshold");
    check("R2 user12 clean", 64'(over_mask), 64'(0));
    do_ack(3); do_ack(11); do_ack(12);

    // R5 limit code 2 -> n = 3
    set_lim(1, 2);
    clear_mx(); mxa[1][0] = 2000;
    run_cycle(5, "R5 first");
    run_cycle(5, "R5 second");
    check("R5 still permitted after 2", 64'(permit[5]), 64'(1));
    run_cycle(5, "R5 third");
    check("R5 blocked after 3", 64'(permit[5]), 64'(0));

    // R4 all four windows over counts once
    clear_mx();
    for (int w = 0; w < NW; w++) mxa[1][w] = 3000;
    run_cycle(6, "R4 four windows");
    check("R4 one count per cycle", 64'(permit[6]), 64'(1));
    run_cycle(6, "R4 four windows");
    run_cycle(6, "R4 four windows");
    check("R4 blocked on third cycle", 64'(permit[6]), 64'(0));

    // R6 only owners dropped
    check("R6 others untouched", 64'(permit), 64'(~((64'(1) << 5) | (64'(1) << 6)) & 64'hFFFF_FFFF));

    // R7 clean cycle does not restore
    clear_mx();
    run_cycle(5, "R7 clean after block");
    check("R7 stays blocked", 64'(permit[5]), 64'(0));

    // R8 ack clears latch and counts
    do_ack(5);
    check("R8 user6 still blocked", 64'(permit[6]), 64'(0));
    clear_mx(); mxa[1][3] = 2000;
    run_cycle(5, "R8 after ack");
    run_cycle(5, "R8 after ack");
    check("R8 counts restarted", 64'(permit[5]), 64'(1));
    do_ack(5); do_ack(6);

    // R9 clean-clear on
    set_clr(1);
    clear_mx(); mxa[1][1] = 2000;
    run_cycle(7, "R9 clr on"); run_cycle(7, "R9 clr on");
    clear_mx(); run_cycle(7, "R9 clr on clean");
    mxa[1][1] = 2000; run_cycle(7, "R9 clr on");
    check("R9 clear kept permit", 64'(permit[7]), 64'(1));
    // R9 clean-clear off
    set_clr(0);
    clear_mx(); mxa[1][1] = 2000; run_cycle(8, "R9 clr off");
    clear_mx(); run_cycle(8, "R9 clr off clean");
    mxa[1][1] = 2000; run_cycle(8, "R9 clr off");
    run_cycle(8, "R9 clr off");
    check("R9 held count blocks", 64'(permit[8]), 64'(0));
    do_ack(7); do_ack(8);

    // R10 per-channel counts
    set_lim(2, 2);
    for (int i = 0; i < 4; i++) begin
      clear_mx();
      if (i % 2 == 0) mxa[1][0] = 2000; else mxa[2][0] = 2000;
      run_cycle(9, "R10 alternating channels");
    end
    check("R10 no cross-channel sum", 64'(permit[9]), 64'(1));
    do_ack(9);

    // R5 limit code 0 -> blocks on first
    set_lim(3, 0);
    clear_mx(); mxa[3][2] = 1200;
    run_cycle(10, "R5 n=1");
    check("R5 n=1 blocks at once", 64'(permit[10]), 64'(0));
    do_ack(10);

    // R3 valid held while busy is taken once
    begin
      int k, nd;
      logic [NC-1:0] em;
      clear_mx(); mxa[0][1] = 1300;
      em = exp_mask(13);
      @(negedge clk);
      cyc_user = 5'd13; load_max(); cyc_valid = 1;
      k = 0; nd = 0;
      while (nd == 0 && k < 100) begin
        @(negedge clk); k++;
        if (done) begin nd++; cyc_valid = 0; end
        else if (cyc_ready) begin
          n_chk++; n_err++;
          $display("FAIL R3 ready while busy act=1 exp=0 at k=%0d", k);
        end
      end
      check("R3 held valid latency", 64'(k), 64'(34));
      model_update(13, em);
      repeat (40) begin @(negedge clk); if (done) nd++; end
      check("R3 single take", 64'(nd), 64'(1));
      check("R3 permit after held valid", 64'(permit), 64'(exp_perm()));
    end

    // random phase
    for (int it = 0; it < 80; it++) begin
      int u;
      if ($urandom_range(0, 9) == 0) set_lim($urandom_range(0, NC-1), $urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) set_clr(1'($urandom_range(0, 1)));
      u = $urandom_range(0, 7);
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < NW; w++) mxa[c][w] = $urandom_range(0, 1030);
      run_cycle(u, "R2/R5/R9 random");
      if ($urandom_range(0, 5) == 0) do_ack($urandom_range(0, 7));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule